// File: doc/BRIEF.md
# Single-Wire Bus Transceiver Mode Controller

This block is the digital sequencer inside a single-wire automotive bus transceiver. It steps the device through five modes: power-on reset, Ready, Operation, Transmitter Off and Power-Down. For each mode it sets four enables: transmitter, receiver, external regulator and the termination pull-up switch. Its inputs are the chip-select, transmit-data and wake pin levels, which are already synchronized to the clock. It also takes a supply-undervoltage flag, a qualified bus-wake event and a vector of fault flags. The fault flags cover thermal overload, bus contention, receive-line monitor failure and dominant timeout. The timers and sensors that raise these flags are outside the block.

Chip-select passes through a glitch filter before the controller uses it. A host that raises chip-select moves the device out of Ready into Operation or Transmitter Off, chosen by the transmit-data level at that time. When chip-select falls, the device goes to Power-Down. Any fault parks the transmitter in Transmitter Off. The device recovers from there once transmit data is high and no fault or undervoltage is present. While the transmitter is disabled, the internal transmit data is held recessive.

Top module: `lin_mode_ctrl`

## Requirements
- R1: While reset is active the mode output is 0 (power-on reset). All four enables are 0 and `txd_int` is 1.
- R2: In power-on reset the mode stays 0 while `uv_in` is 1. The first clock edge that samples `uv_in` at 0 moves it to Ready (mode 1).
- R3: In Ready, `rx_en` is 1 and `reg_en` is 1 (while `uv_in` is 0), and `tx_en` and `pullup_en` are 0. The mode remains Ready while the filtered chip-select is low.
- R4: In Ready, a filtered chip-select of 1 moves the mode on the next edge. It goes to Operation (mode 2) if `txd_in` is 1, or to Transmitter Off (mode 3) if `txd_in` is 0.
- R5: In Operation all four enables are 1. `pullup_en` is 1 in no other mode.
- R6: In Operation, any bit of `fault_in` at 1 moves the mode to Transmitter Off on the next edge. Every bit has the same effect.
- R7: In Transmitter Off the mode returns to Operation on the next edge only when `txd_in` is 1, `fault_in` is all zero and `uv_in` is 0. Otherwise it stays in Transmitter Off.
- R8: A falling edge of the filtered chip-select in Operation or Transmitter Off moves the mode to Power-Down (mode 4). It reaches mode 4 one edge after the filtered level drops. In Power-Down, `tx_en`, `rx_en`, `reg_en` and `pullup_en` are all 0.
- R9: In Power-Down, a filtered chip-select of 1, a falling edge on `wake_in` or `bus_wake_in` at 1 moves the mode to Ready. If the filtered chip-select is 1, the mode proceeds from Ready on the following edge as in R4.
- R10: `txd_int` equals `txd_in` while `tx_en` is 1 and is 1 whenever `tx_en` is 0.
- R11: `uv_in` at 1 in Operation moves the mode to Transmitter Off on the next edge. `reg_en` is 0 in every mode while `uv_in` is 1.
- R12: The filtered chip-select takes the level of `cs_in` only after `cs_in` has differed from it on FILT_CYC consecutive clock edges (default 4). A shorter pulse has no effect on the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_in | input | 1 | Synchronized chip-select level |
| txd_in | input | 1 | Synchronized transmit-data level (1 = recessive) |
| wake_in | input | 1 | Synchronized wake pin level, idle high |
| bus_wake_in | input | 1 | Qualified bus wake event, active high |
| uv_in | input | 1 | Supply below undervoltage threshold |
| fault_in | input | FLT_W | Fault flags: thermal, contention, receive monitor, dominant timeout |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| reg_en | output | 1 | External regulator enable |
| pullup_en | output | 1 | Termination pull-up switch |
| txd_int | output | 1 | Internal transmit data after recessive forcing |
| mode_o | output | 3 | Current mode: 0 reset, 1 Ready, 2 Operation, 3 Transmitter Off, 4 Power-Down |

## Verification
The bench sends a chip-select pulse one cycle shorter than the filter window. A filter that counted wrongly would let the mode leave Ready on that glitch. Each fault bit is raised on its own in Operation, and the fault is held while transmit data is high. This exposes a missed fault bit or a recovery that ignores a fault still present. Power-Down is entered from both Operation and Transmitter Off and left through all three wake causes. The chip-select wake must pass through Ready for exactly one cycle before Operation. A controller that skipped Ready, or that ignored the transmit level when leaving it, would show the wrong mode on that cycle.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;
   typedef enum logic [2:0] {
      M_POR   = 3'd0,
      M_READY = 3'd1,
      M_OPER  = 3'd2,
      M_TXOFF = 3'd3,
      M_PDOWN = 3'd4
   } mode_e;
endpackage

// File: rtl/cs_glitch_filter.sv
module cs_glitch_filter #(
   parameter int FILT_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic flt_o
);
   localparam int CNT_W = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC);

   generate
      if (FILT_CYC < 0) begin : g_bad
         $error("cs_glitch_filter: FILT_CYC must not be negative");
      end
      if (FILT_CYC == 0) begin : g_bypass
         assign flt_o = raw_i;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         logic             lvl_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               lvl_q <= 1'b0;
            end else if (raw_i != lvl_q) begin
               if (cnt_q == CNT_W'(FILT_CYC - 1)) begin
                  lvl_q <= raw_i;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end else begin
               cnt_q <= '0;
            end
         end
         assign flt_o = lvl_q;

         // R12: an input that agrees with the filtered level leaves it untouched
         p_filt_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (raw_i == flt_o) |=> $stable(flt_o));
      end
   endgenerate
endmodule

// File: rtl/fall_detect.sv
module fall_detect #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_i,
   output logic fall_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= sig_i;
   end

   assign fall_o = prev_q & ~sig_i;
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
   import lin_mode_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  cs_lvl,
   input  logic  cs_fall,
   input  logic  txd,
   input  logic  wake_fall,
   input  logic  bus_wake,
   input  logic  uv,
   input  logic  fault_any,
   output mode_e mode_q
);
   mode_e mode_d;

   always_comb begin
      mode_d = mode_q;
      unique case (mode_q)
         M_POR:   if (!uv) mode_d = M_READY;
         M_READY: if (cs_lvl) mode_d = txd ? M_OPER : M_TXOFF;
         M_OPER: begin
            if (cs_fall)              mode_d = M_PDOWN;
            else if (fault_any || uv) mode_d = M_TXOFF;
         end
         M_TXOFF: begin
            if (cs_fall)                         mode_d = M_PDOWN;
            else if (txd && !fault_any && !uv)   mode_d = M_OPER;
         end
         M_PDOWN: if (cs_lvl || wake_fall || bus_wake) mode_d = M_READY;
         default: mode_d = M_POR;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= M_POR;
      else        mode_q <= mode_d;
   end

   // R2: reset mode is held while the supply is low
   p_por_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == M_POR && uv) |=> mode_q == M_POR);
   // R4: select with recessive transmit data leaves Ready for Operation
   p_ready_oper_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == M_READY && cs_lvl && txd) |=> mode_q == M_OPER);
   // R6: a fault in Operation parks the transmitter
   p_fault_park_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == M_OPER && !cs_fall && fault_any) |=> mode_q == M_TXOFF);
   // R7: no return to Operation while a fault remains
   p_no_recover_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == M_TXOFF && fault_any) |=> mode_q != M_OPER);
   // R8: deselect from an active mode powers down
   p_pdown_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == M_OPER || mode_q == M_TXOFF) && cs_fall) |=> mode_q == M_PDOWN);
   // R9: a wake pin falling edge leaves Power-Down for Ready
   p_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == M_PDOWN && wake_fall) |=> mode_q == M_READY);
endmodule

// File: rtl/mode_decode.sv
module mode_decode
   import lin_mode_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  mode_e mode,
   input  logic  uv,
   input  logic  txd,
   output logic  tx_en,
   output logic  rx_en,
   output logic  reg_en,
   output logic  pullup_en,
   output logic  txd_int
);
   logic active;

   assign active    = (mode == M_READY) || (mode == M_OPER) || (mode == M_TXOFF);
   assign tx_en     = (mode == M_OPER);
   assign rx_en     = active;
   assign reg_en    = active && !uv;
   assign pullup_en = (mode == M_OPER);
   assign txd_int   = tx_en ? txd : 1'b1;

   // R10: transmit data is recessive whenever the driver is off
   p_txd_rec_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |-> txd_int);
   // R5: termination is switched in only with the driver enabled
   p_pullup_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pullup_en |-> (tx_en && rx_en));
   // R11: a low supply always removes the regulator enable
   p_uv_reg_r11: assert property (@(posedge clk) disable iff (!rst_n)
      uv |-> !reg_en);
endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
   import lin_mode_pkg::*;
#(
   parameter int FILT_CYC = 4,
   parameter int FLT_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_in,
   input  logic             txd_in,
   input  logic             wake_in,
   input  logic             bus_wake_in,
   input  logic             uv_in,
   input  logic [FLT_W-1:0] fault_in,
   output logic             tx_en,
   output logic             rx_en,
   output logic             reg_en,
   output logic             pullup_en,
   output logic             txd_int,
   output logic [2:0]       mode_o
);
   generate
      if (FLT_W < 1) begin : g_bad_flt
         $error("lin_mode_ctrl: FLT_W must be at least 1");
      end
   endgenerate

   logic  cs_lvl;
   logic  cs_fall;
   logic  wake_fall;
   logic  fault_any;
   mode_e mode;

   assign fault_any = |fault_in;

   cs_glitch_filter #(.FILT_CYC(FILT_CYC)) u_cs_filt (
      .clk(clk), .rst_n(rst_n), .raw_i(cs_in), .flt_o(cs_lvl));

   fall_detect #(.RST_VAL(1'b0)) u_cs_edge (
      .clk(clk), .rst_n(rst_n), .sig_i(cs_lvl), .fall_o(cs_fall));

   fall_detect #(.RST_VAL(1'b1)) u_wake_edge (
      .clk(clk), .rst_n(rst_n), .sig_i(wake_in), .fall_o(wake_fall));

   mode_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .cs_lvl(cs_lvl), .cs_fall(cs_fall),
      .txd(txd_in), .wake_fall(wake_fall), .bus_wake(bus_wake_in),
      .uv(uv_in), .fault_any(fault_any), .mode_q(mode));

   mode_decode u_dec (
      .clk(clk), .rst_n(rst_n), .mode(mode), .uv(uv_in), .txd(txd_in),
      .tx_en(tx_en), .rx_en(rx_en), .reg_en(reg_en),
      .pullup_en(pullup_en), .txd_int(txd_int));

   assign mode_o = mode;
endmodule

// File: tb/tb_lin_mode_ctrl.sv
`timescale 1ns/1ps
module tb_lin_mode_ctrl;
   localparam int FILT = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_in = 1'b0, txd_in = 1'b1, wake_in = 1'b1, bus_wake_in = 1'b0, uv_in = 1'b1;
   logic [3:0] fault_in = 4'b0;
   logic       tx_en, rx_en, reg_en, pullup_en, txd_int;
   logic [2:0] mode_o;

   int total = 0, bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   lin_mode_ctrl #(.FILT_CYC(FILT), .FLT_W(4)) dut (
      .clk(clk), .rst_n(rst_n), .cs_in(cs_in), .txd_in(txd_in), .wake_in(wake_in),
      .bus_wake_in(bus_wake_in), .uv_in(uv_in), .fault_in(fault_in),
      .tx_en(tx_en), .rx_en(rx_en), .reg_en(reg_en), .pullup_en(pullup_en),
      .txd_int(txd_int), .mode_o(mode_o));

   // behavioural reference
   int m = 0, fcnt = 0;
   bit cf = 0, csp = 0, wp = 1;

   function automatic logic [5:0] model_out(int md);
      bit te, re, ge, pe, ti;
      te = (md == 2);
      re = (md >= 1 && md <= 3);
      ge = re && !uv_in;
      pe = (md == 2);
      ti = te ? txd_in : 1'b1;
      return {1'b0, te, re, ge, pe, ti};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m = 0; fcnt = 0; cf = 0; csp = 0; wp = 1;
      end else begin
         bit fall, wf;
         fall = csp && !cf;
         wf = wp && !wake_in;
         case (m)
            0: if (!uv_in) m = 1;
            1: if (cf) m = txd_in ? 2 : 3;
            2: if (fall) m = 4; else if (fault_in != 0 || uv_in) m = 3;
            3: if (fall) m = 4; else if (txd_in && fault_in == 0 && !uv_in) m = 2;
            4: if (cf || wf || bus_wake_in) m = 1;
            default: m = 0;
         endcase
         csp = cf;
         wp = wake_in;
         if (cs_in != cf) begin
            fcnt++;
            if (fcnt >= FILT) begin cf = cs_in; fcnt = 0; end
         end else fcnt = 0;
      end
      #1;
      if (rst_n) begin
         logic [5:0] e, a;
         e = model_out(m);
         a = {1'b0, tx_en, rx_en, reg_en, pullup_en, txd_int};
         total++;
         if (a != e || mode_o != 3'(m)) begin
            bad++;
            $display("FAIL model-compare R3 R5 R10 R11 t=%0t act mode=%0d out=%b exp mode=%0d out=%b",
                     $time, mode_o, a, m, e);
         end
      end
   end

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #1.5;
   endtask

   task automatic drv();
      @(negedge clk);
   endtask

   initial begin
      tick(3);
      // R1 reset state
      chk("R1 mode", mode_o, 0);
      chk("R1 enables", {tx_en, rx_en, reg_en, pullup_en}, 0);
      chk("R1 txd_int", txd_int, 1);
      drv(); rst_n = 1;
      tick(3);
      chk("R2 hold in reset mode", mode_o, 0);
      drv(); uv_in = 0;
      tick(1);
      chk("R2 to Ready", mode_o, 1);
      chk("R3 ready enables", {tx_en, rx_en, reg_en, pullup_en}, 4'b0110);
      // R12 glitch one cycle short of the window
      drv(); cs_in = 1;
      repeat (FILT - 2) drv();
      drv(); cs_in = 0;
      tick(6);
      chk("R12 glitch ignored", mode_o, 1);
      // R4 select with dominant transmit data
      drv(); txd_in = 0; cs_in = 1;
      tick(FILT);
      chk("R12 not yet filtered", mode_o, 1);
      tick(1);
      chk("R4 to TxOff", mode_o, 3);
      chk("R10 forced recessive", txd_int, 1);
      drv(); txd_in = 1;
      tick(1);
      chk("R7 recover", mode_o, 2);
      chk("R5 oper enables", {tx_en, rx_en, reg_en, pullup_en}, 4'b1111);
      drv(); txd_in = 0;
      #1;
      chk("R10 follows pin", txd_int, 0);
      drv(); txd_in = 1;
      // R6 each fault bit
      for (int i = 0; i < 4; i++) begin
         drv(); fault_in = 4'(1 << i);
         tick(1);
         chk("R6 fault parks", mode_o, 3);
         chk("R5 pullup off", pullup_en, 0);
         tick(2);
         chk("R7 held by fault", mode_o, 3);
         drv(); fault_in = 0;
         tick(1);
         chk("R7 recover after fault", mode_o, 2);
      end
      // R11 undervoltage
      drv(); uv_in = 1;
      tick(1);
      chk("R11 uv parks", mode_o, 3);
      chk("R11 reg off", reg_en, 0);
      drv(); uv_in = 0;
      tick(1);
      chk("R11 recover", mode_o, 2);
      chk("R11 reg on", reg_en, 1);
      // R8 from Operation
      drv(); cs_in = 0;
      tick(FILT + 1);
      chk("R8 pdown from oper", mode_o, 4);
      chk("R8 pdown enables", {tx_en, rx_en, reg_en, pullup_en}, 0);
      chk("R10 pdown txd", txd_int, 1);
      // R9 wake pin
      drv(); wake_in = 0;
      tick(1);
      chk("R9 wake pin", mode_o, 1);
      drv(); wake_in = 1;
      tick(2);
      chk("R3 stays ready cs low", mode_o, 1);
      // R8 from Transmitter Off
      drv(); cs_in = 1;
      tick(FILT + 1);
      chk("R4 to oper", mode_o, 2);
      drv(); txd_in = 0; fault_in = 4'b0001;
      tick(1);
      chk("R6 park", mode_o, 3);
      drv(); fault_in = 0; cs_in = 0;
      tick(FILT + 1);
      chk("R8 pdown from txoff", mode_o, 4);
      // R9 bus wake
      drv(); bus_wake_in = 1;
      drv(); bus_wake_in = 0; txd_in = 1;
      #1.5;
      chk("R9 bus wake", mode_o, 1);
      drv(); cs_in = 1;
      tick(FILT + 1);
      chk("R4 oper again", mode_o, 2);
      drv(); cs_in = 0;
      tick(FILT + 1);
      chk("R8 pdown again", mode_o, 4);
      // R9 chip-select wake passes through Ready
      drv(); cs_in = 1;
      tick(FILT + 1);
      chk("R9 cs wake ready", mode_o, 1);
      tick(1);
      chk("R9 cs wake proceeds", mode_o, 2);
      tick(2);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule